// File: doc/BRIEF.md
# Fractional-N Main Feedback Divider

This block is the programmable feedback divider of a fractional-N frequency synthesizer. It runs on the prescaled oscillator clock and counts out one division cycle after another. Each cycle lasts either N or N+1 input clocks. The choice comes from a small fractional accumulator that adds an increment NF at every cycle boundary and wraps at a selectable modulus of 5 or 8. Over one full wrap the average ratio is N + NF/modulus.

At the end of every division cycle the block emits a one-clock pulse toward the phase detector. It also exports the accumulator value as an amplitude code, together with a compensation window of fixed length that opens at the start of each cycle. An analog compensation source uses the two to cancel the fractional phase ripple. New ratio settings are taken only at a cycle boundary. A power-down input stops the divider, and releasing it restarts the count from a known point, so the divider runs in step with a reference divider that is released on the same clock.

Top module: `fracn_main_div`

## Requirements
- R1: While reset is applied, and afterwards while `pd_i` stays high, `div_pulse_o` and `comp_win_o` are 0 and `frd_o` is 0.
- R2: The clock edge on which `pd_i` is first seen low starts the divider, with the accumulator at 0. `div_pulse_o` is then high during the N-th clock counted from that start edge, so the first cycle lasts exactly N clocks.
- R3: `div_pulse_o` is high for exactly one clock per division cycle. The number of clocks from one pulse to the next equals the ratio of that cycle.
- R4: At every cycle boundary the accumulator becomes (acc + NF) mod M. M is 8 when `mod5_i` = 0 and 5 when `mod5_i` = 1. The cycle that follows lasts N+1 clocks if acc + NF >= M and N clocks otherwise, and never more than N+1, even when NF >= M.
- R5: `frd_o` shows the accumulator. It changes only on the boundary edge, so the clock after a pulse already shows the new value.
- R6: `comp_win_o` is high for exactly 128 consecutive clocks (parameter WIN_LEN), starting on the clock after each pulse and on the clock after the start edge.
- R7: `n_i`, `nf_i` and `mod5_i` are sampled only on the boundary edge. A change in the middle of a cycle does not alter the length of that cycle.
- R8: When `pd_i` is high at a clock edge, the pulse and the window are low from that edge on, and the accumulator clears to 0. When `pd_i` goes low again, the divider restarts as in R2.
- R9: A ratio `n_i` below 512 (parameter N_MIN) is treated as 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaled oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pd_i | input | 1 | Power-down; high stops the divider, the falling edge restarts it |
| n_i | input | 16 | Integer ratio N |
| nf_i | input | 3 | Fractional increment NF |
| mod5_i | input | 1 | Modulus select: 0 gives modulo 8, 1 gives modulo 5 |
| div_pulse_o | output | 1 | One-clock pulse in the last clock of each division cycle |
| comp_win_o | output | 1 | Compensation window, 128 clocks per cycle |
| frd_o | output | 3 | Accumulator value, used as the compensation amplitude code |

## Verification
The pulse of the first cycle is due in the N-th clock after the edge on which power-down is seen low, and each later pulse is due exactly one ratio after the one before. The bench counts negative-edge samples from the start point, or from the last pulse, and compares that count with the ratio its own model queued at the previous boundary. The window is checked on the first sample after each boundary and by its total high count up to the next pulse. The accumulator code is checked on that same first sample. Settings are changed a clock after a rising edge in the middle of a cycle, so the model applies them at the next boundary, which is where the design must apply them.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // Width of the fractional increment and accumulator.
  localparam int FRAC_W = 3;
  // One extra bit holds the sum before it is reduced.
  localparam int SUM_W  = FRAC_W + 1;

  typedef enum logic {
    FMOD_EIGHT = 1'b0,
    FMOD_FIVE  = 1'b1
  } fmod_e;

  localparam logic [SUM_W-1:0] MODV_EIGHT = SUM_W'(8);
  localparam logic [SUM_W-1:0] MODV_FIVE  = SUM_W'(5);
endpackage

// File: rtl/fracn_rst_sync.sv
module fracn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/fracn_accum.sv
// Step of the fractional accumulator: add the increment, reduce by the
// modulus (twice if needed), report a wrap. Only one wrap is reported.
module fracn_accum
  import fracn_pkg::*;
(
  input  logic [FRAC_W-1:0] acc_i,
  input  logic [FRAC_W-1:0] inc_i,
  input  fmod_e             fmod_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              wrap_o
);
  logic [SUM_W-1:0] sum, modv, once, twice;

  always_comb begin
    sum    = {1'b0, acc_i} + {1'b0, inc_i};
    modv   = (fmod_i == FMOD_FIVE) ? MODV_FIVE : MODV_EIGHT;
    wrap_o = (sum >= modv);
    once   = sum - modv;
    twice  = once - modv;
    if (!wrap_o)           acc_o = sum[FRAC_W-1:0];
    else if (once >= modv) acc_o = twice[FRAC_W-1:0];
    else                   acc_o = once[FRAC_W-1:0];
  end
endmodule

// File: rtl/fracn_cycle_cnt.sv
// Down counter for one division cycle; terminal when it reaches zero.
module fracn_cycle_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tc_o = run_i & (cnt_q == '0);
endmodule

// File: rtl/fracn_comp_window.sv
// Window that is high for WIN_LEN clocks after each trigger.
module fracn_comp_window #(
  parameter int WIN_LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic clr_i,
  output logic win_o
);
  localparam int WC_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_LEN - 1);

  logic            act_q, act_d;
  logic [WC_W-1:0] wcnt_q, wcnt_d;

  always_comb begin
    act_d  = act_q;
    wcnt_d = wcnt_q;
    if (clr_i) begin
      act_d  = 1'b0;
      wcnt_d = '0;
    end else if (trig_i) begin
      act_d  = 1'b1;
      wcnt_d = '0;
    end else if (act_q) begin
      if (wcnt_q == WC_LAST) act_d = 1'b0;
      else                   wcnt_d = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      act_q  <= act_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign win_o = act_q;
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
  import fracn_pkg::*;
#(
  parameter int N_W        = 16,
  parameter int N_MIN      = 512,
  parameter int WIN_LEN    = 128,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [FRAC_W-1:0] nf_i,
  input  logic              mod5_i,
  output logic              div_pulse_o,
  output logic              comp_win_o,
  output logic [FRAC_W-1:0] frd_o
);
  localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

  logic              rst_sync_n;
  logic              idle_q, idle_d;
  logic              start, tc, load;
  logic [N_W-1:0]    n_eff, reload_val;
  logic [FRAC_W-1:0] acc_q, acc_d, step_acc;
  logic              step_wrap;

  fracn_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  fracn_accum u_acc (
    .acc_i  (acc_q),
    .inc_i  (nf_i),
    .fmod_i (fmod_e'(mod5_i)),
    .acc_o  (step_acc),
    .wrap_o (step_wrap)
  );

  // Boundary control: settings are sampled only when a cycle is (re)loaded.
  always_comb begin
    n_eff      = (n_i < N_FLOOR) ? N_FLOOR : n_i;
    start      = idle_q & ~pd_i;
    load       = start | tc;
    reload_val = n_eff - N_W'(1) + {{(N_W-1){1'b0}}, tc & step_wrap};
    idle_d     = pd_i;
    if (pd_i || start) acc_d = '0;
    else if (tc)       acc_d = step_acc;
    else               acc_d = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idle_q <= 1'b1;
      acc_q  <= '0;
    end else begin
      idle_q <= idle_d;
      acc_q  <= acc_d;
    end
  end

  fracn_cycle_cnt #(.CNT_W(N_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .run_i      (~idle_q),
    .load_i     (load),
    .load_val_i (reload_val),
    .tc_o       (tc)
  );

  fracn_comp_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .trig_i (load),
    .clr_i  (pd_i),
    .win_o  (comp_win_o)
  );

  assign div_pulse_o = tc;
  assign frd_o       = acc_q;
endmodule

// File: rtl/fracn_main_div_chk.sv
module fracn_main_div_chk
  import fracn_pkg::*;
#(
  parameter int N_W     = 16,
  parameter int N_MIN   = 512,
  parameter int WIN_LEN = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pd_i,
  input logic              div_pulse_o,
  input logic              comp_win_o,
  input logic [FRAC_W-1:0] frd_o
);
  localparam int RUN_W = $clog2(WIN_LEN) + 2;
  localparam int GAP_W = N_W + 1;
  localparam logic [RUN_W-1:0] RUN_LEN = RUN_W'(WIN_LEN);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(N_MIN - 1);
  localparam logic [GAP_W-1:0] GAP_TOP = '1;

  logic [RUN_W-1:0] run_q;
  logic [GAP_W-1:0] gap_q;
  logic             pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      gap_q <= '0;
      pd_q  <= 1'b1;
    end else begin
      pd_q  <= pd_i;
      run_q <= comp_win_o ? run_q + 1'b1 : '0;
      if (div_pulse_o)          gap_q <= '0;
      else if (gap_q != GAP_TOP) gap_q <= gap_q + 1'b1;
    end
  end

  a_r3_pulse_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);

  a_r9_pulse_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> gap_q >= GAP_MIN);

  a_r6_win_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && !pd_i) |=> comp_win_o);

  a_r6_win_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_win_o |-> run_q < RUN_LEN);

  a_r6_win_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!comp_win_o && run_q != '0 && !pd_q) |-> run_q == RUN_LEN);

  a_r8_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!div_pulse_o && !comp_win_o && frd_o == '0));

  a_r5_frd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_pulse_o && !pd_i) |=> $stable(frd_o));
endmodule

bind fracn_main_div fracn_main_div_chk #(
  .N_W     (N_W),
  .N_MIN   (N_MIN),
  .WIN_LEN (WIN_LEN)
) u_chk (.*);

// File: tb/tb_fracn_main_div.sv
module tb_fracn_main_div;
  localparam int NW   = 16;
  localparam int NMIN = 512;
  localparam int WIN  = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pd;
  logic [NW-1:0] n;
  logic [2:0]    nf;
  logic          m5;
  logic          pulse, win;
  logic [2:0]    frd;

  always #4 clk = ~clk;

  fracn_main_div dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pd_i        (pd),
    .n_i         (n),
    .nf_i        (nf),
    .mod5_i      (m5),
    .div_pulse_o (pulse),
    .comp_win_o  (win),
    .frd_o       (frd)
  );

  int    total = 0;
  int    bad   = 0;
  int    expq[$];
  int    since, wins, m_acc, pulses;
  bit    first_after;
  bit    mon_en = 1'b0;
  bit    done   = 1'b0;
  string cur_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampn(input int v);
    return (v < NMIN) ? NMIN : v;
  endfunction

  // Scoreboard monitor: pops the expected length at each pulse and pushes
  // the model's prediction for the cycle that the boundary edge starts.
  always @(negedge clk) begin
    int  expv, sum, md;
    bit  ovf;
    if (mon_en) begin
      since++;
      if (win) wins++;
      if (first_after) begin
        chk(win === 1'b1, "R6 window opens after boundary", int'(win), 1);
        chk(int'(frd) == m_acc, "R5 frd code after boundary", int'(frd), m_acc);
        chk(pulse === 1'b0, "R3 pulse one clock wide", int'(pulse), 0);
        first_after = 1'b0;
      end
      if (pulse) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3 pulse with nothing expected", since, 0);
        end else begin
          expv = expq.pop_front();
          chk(since == expv, {"R3 cycle length, ", cur_tag}, since, expv);
        end
        chk(wins == WIN, "R6 window width per cycle", wins, WIN);
        sum   = m_acc + int'(nf);
        md    = m5 ? 5 : 8;
        ovf   = (sum >= md);
        m_acc = sum % md;
        expq.push_back(clampn(int'(n)) + int'(ovf));
        since       = 0;
        wins        = 0;
        first_after = 1'b1;
        pulses++;
      end
    end
  end

  task automatic quiet(input int k, input string tag);
    bit ok = 1'b1;
    repeat (k) begin
      @(negedge clk);
      if (pulse !== 1'b0 || win !== 1'b0 || frd !== 3'd0) ok = 1'b0;
    end
    chk(ok, tag, int'(ok), 1);
  endtask

  // Driver: releases power-down and queues the first cycle (ratio N, acc 0).
  task automatic start_run(input string tag);
    @(negedge clk);
    #1;
    cur_tag     = tag;
    pd          = 1'b0;
    since       = 0;
    wins        = 0;
    m_acc       = 0;
    first_after = 1'b1;
    expq.delete();
    expq.push_back(clampn(int'(n)));
    mon_en      = 1'b1;
  endtask

  task automatic set_cfg(input int nv, input int nfv, input bit m5v, input int dly,
                         input string tag);
    repeat (dly) @(posedge clk);
    #1;
    n       = NW'(nv);
    nf      = 3'(nfv);
    m5      = m5v;
    cur_tag = tag;
  endtask

  task automatic wait_pulses(input int k);
    int tgt = pulses + k;
    while (pulses < tgt) @(posedge clk);
  endtask

  initial begin
    rst_n  = 1'b0;
    pd     = 1'b1;
    n      = NW'(600);
    nf     = 3'd0;
    m5     = 1'b0;
    pulses = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pulse === 1'b0, "R1 pulse low in reset", int'(pulse), 0);
    chk(win === 1'b0, "R1 window low in reset", int'(win), 0);
    chk(frd === 3'd0, "R1 frd zero in reset", int'(frd), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    quiet(40, "R1 idle while power-down held");

    // R2: first cycle lasts N, then integer-only cycles
    start_run("R2 first cycle N");
    wait_pulses(3);
    // R4 / R7: modulo 8, changed mid-cycle
    set_cfg(600, 3, 1'b0, 200, "R4 R7 mod8 nf3");
    wait_pulses(10);
    // R4 / R7: modulo 5 with new N, changed mid-cycle
    set_cfg(700, 2, 1'b1, 150, "R4 R7 mod5 nf2");
    wait_pulses(10);
    // R4: increment not below the modulus, ratio capped at N+1
    set_cfg(700, 7, 1'b1, 50, "R4 capped nf7 mod5");
    wait_pulses(8);
    // R9: small ratio clamped to 512
    set_cfg(100, 1, 1'b0, 300, "R9 clamp");
    wait_pulses(5);

    // R8: power-down in the middle of a cycle
    repeat (100) @(posedge clk);
    #1;
    pd     = 1'b1;
    mon_en = 1'b0;
    @(posedge clk);
    quiet(300, "R8 outputs quiet in power-down");
    n  = NW'(530);
    nf = 3'd5;
    m5 = 1'b0;
    start_run("R8 R2 restart after power-down");
    wait_pulses(6);

    mon_en = 1'b0;
    done   = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", pulses, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule